// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire management bus used to configure Ethernet PHYs. Software programs a control word that holds the clock divisor, the preamble switch, a page-select mode and a timeout limit. It then writes one prepacked command word into the data register. The block serializes that word onto `mdioOut` and `mdioOe`, clocked by a divided `mdc`. On a read it lets go of the line after the first turnaround bit and shifts the PHY's reply in from `mdioIn`. When the frame has gone out, a completion flag rises and the read data can be fetched from the low half of the data register.

When page-select mode is on, every command is preceded by an automatic write frame. This frame goes to PHY address 0, register 0x1F, and carries the target PHY number moved up by four bit places. A programmable timeout counts MDC cycles. If a transaction needs more cycles than the limit allows, it is cut short and an error flag is raised.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0, the data register reads 0, `mdc` is low and `mdioOe` is low.
- R2: A write to the data register (offset 0x12C) starts a frame only when bit 30 is 1 and exactly one of bit 29 (read) and bit 28 (write) is 1. Any other value is ignored: no MDC edge appears and busy stays 0.
- R3: A frame is 32 bits, sent MSB first. The first two bits are 0 then 1, followed by command bits 29:28 as the opcode, bits 27:23 as the PHY address and bits 22:18 as the register address. The turnaround is sent as 1 then 0, and bits 15:0 follow. `mdioOut` changes only on an MDC falling edge.
- R4: When a frame ends, control bit 8 (done) becomes 1 and control bit 9 (busy) becomes 0. Done and busy are never 1 at the same time.
- R5: On a read, `mdioOe` is low from frame position 15 (the second turnaround bit) to the end of the frame. `mdioIn` is sampled at the MDC rising edges of positions 16 to 31.
- R6: After a read, the data register returns the 16 received bits in bits 15:0, with the first received bit in bit 15, and zeros above them.
- R7: Control bit 9 is 1 while a transaction runs. A data-register write made while busy is ignored.
- R8: A write to the control register (offset 0x128) while idle loads bits 3:0 (divisor), bit 7 (preamble), bit 11 (page mode) and bits 31:16 (timeout limit). The same write clears done and error. Writing 0 returns the register to 0.
- R9: With control bit 11 set, the command frame is preceded by a write frame with PHY address 0, register 0x1F and data equal to command bits 27:23 shifted left by 4. Done rises only after the command frame.
- R10: With a nonzero limit L in control bits 31:16, a transaction that needs more than L MDC cycles stops after exactly L MDC rising edges. Error bit 10 is then 1, done is 0, busy is 0 and `mdc` stays low.
- R11: With control bit 7 set, each frame (including the page-select frame) is preceded by 32 driven ones.
- R12: `mdc` is low when idle. While busy it toggles every divisor+1 clocks, so its period is 2*(divisor+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational on busAddr) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for the data pin |
| mdioIn | input | 1 | Serial data from the pin |

## Verification
The bench uses the default parameters: a 12-bit offset bus with the two registers at 0x128 and 0x12C, and a 4-bit divisor field. It programs divisors of 0, 1 and 2, so the MDC period of 6 clocks can be measured exactly while frames stay short. A timeout limit of 10 brings the abort path within a few dozen clocks. With preamble and page mode both enabled, a 128-bit two-frame sequence is covered in a few hundred cycles. A PHY model answers reads only while the pin is released, so an early or late release shows up in the received data.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;

  // command word bit positions (software contract)
  localparam int CMD_START = 30;
  localparam int CMD_RD    = 29;
  localparam int CMD_WR    = 28;
  localparam int PHY_LSB   = 23;
  localparam int PHY_W     = 5;

  // frame positions used for turnaround release and capture
  localparam int TA2_POS  = 15;
  localparam int DATA_POS = 16;

  // page-select register and shift
  localparam logic [4:0] PAGE_REG = 5'h1F;

  // control register bit positions
  localparam int CTL_PRE     = 7;
  localparam int CTL_DONE    = 8;
  localparam int CTL_BUSY    = 9;
  localparam int CTL_ERR     = 10;
  localparam int CTL_PAGE    = 11;
  localparam int CTL_TMO_LSB = 16;
  localparam int TMO_W       = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_FRM  = 2'd2
  } mdioState_e;

  typedef struct packed {
    logic loadWord;
    logic shiftOut;
    logic capture;
    logic preamble;
  } mdioStrb_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);

  logic [DIV_W-1:0] phaseCnt;
  logic             hit;

  assign hit      = run && (phaseCnt == div);
  assign riseTick = hit && !mdc;
  assign fallTick = hit && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      mdc      <= 1'b0;
    end else if (!run) begin
      phaseCnt <= '0;
      mdc      <= 1'b0;
    end else if (hit) begin
      phaseCnt <= '0;
      mdc      <= ~mdc;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // R12: the clock parks low whenever the engine is stopped
  assert_mdc_idle_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_master_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  mdioStrb_t             strb,
  input  logic [FRAME_BITS-1:0] loadVal,
  input  logic                  mdioIn,
  output logic                  mdioOut,
  output logic [15:0]           rdData
);

  logic [FRAME_BITS-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rdData <= '0;
    end else begin
      if (strb.loadWord) begin
        shReg <= loadVal;
      end else if (strb.shiftOut) begin
        shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.capture) begin
        rdData <= {rdData[14:0], mdioIn};
      end
    end
  end

  assign mdioOut = strb.preamble | shReg[FRAME_BITS-1];

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_master_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWr,
  input  logic                  datWr,
  input  logic [31:0]           wrData,
  input  logic                  riseTick,
  input  logic                  fallTick,
  output logic                  run,
  output logic [DIV_W-1:0]      div,
  output mdioStrb_t             strb,
  output logic [FRAME_BITS-1:0] loadVal,
  output logic                  mdioOe,
  output logic [31:0]           ctlReadback
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] REL_POS  = CNT_W'(TA2_POS);
  localparam logic [CNT_W-1:0] CAP_POS  = CNT_W'(DATA_POS);

  mdioState_e       state;
  logic [CNT_W-1:0] bitCnt;
  logic             preEn;
  logic             pageEn;
  logic             pagePending;
  logic             doneFlag;
  logic             errFlag;
  logic [TMO_W-1:0] tmoLimit;
  logic [TMO_W-1:0] tmoCnt;
  logic [27:0]      cmdReg;   // {cmd[29:18], cmd[15:0]}
  logic             busy;
  logic             cmdValid;
  logic             startReq;
  logic             lastBit;
  logic             finalEnd;
  logic             tmoHit;
  logic             cmdRead;

  function automatic logic [FRAME_BITS-1:0] buildMain(input logic [27:0] f);
    return {2'b01, f[27:16], 2'b10, f[15:0]};
  endfunction

  function automatic logic [FRAME_BITS-1:0] buildPage(input logic [PHY_W-1:0] phy);
    return {2'b01, 2'b01, 5'd0, PAGE_REG, 2'b10, 7'd0, phy, 4'd0};
  endfunction

  assign busy     = (state != ST_IDLE);
  assign run      = busy;
  assign cmdRead  = cmdReg[27];
  assign cmdValid = wrData[CMD_START] && (wrData[CMD_RD] ^ wrData[CMD_WR]);
  assign startReq = datWr && !busy && cmdValid;
  assign lastBit  = fallTick && (state == ST_FRM) && (bitCnt == LAST_POS);
  assign finalEnd = lastBit && !pagePending;
  assign tmoHit   = fallTick && (tmoLimit != '0) && (tmoCnt >= tmoLimit) && !finalEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      preEn       <= 1'b0;
      pageEn      <= 1'b0;
      pagePending <= 1'b0;
      doneFlag    <= 1'b0;
      errFlag     <= 1'b0;
      tmoLimit    <= '0;
      tmoCnt      <= '0;
      cmdReg      <= '0;
      div         <= '0;
    end else begin
      if (ctlWr && !busy) begin
        div      <= wrData[DIV_W-1:0];
        preEn    <= wrData[CTL_PRE];
        pageEn   <= wrData[CTL_PAGE];
        tmoLimit <= wrData[CTL_TMO_LSB +: TMO_W];
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (startReq) begin
        cmdReg      <= {wrData[29:18], wrData[15:0]};
        doneFlag    <= 1'b0;
        errFlag     <= 1'b0;
        tmoCnt      <= '0;
        bitCnt      <= '0;
        pagePending <= pageEn;
        state       <= preEn ? ST_PRE : ST_FRM;
      end else if (busy) begin
        if (riseTick) begin
          tmoCnt <= tmoCnt + 1'b1;
        end
        if (tmoHit) begin
          state   <= ST_IDLE;
          errFlag <= 1'b1;
        end else if (fallTick) begin
          if (bitCnt == LAST_POS) begin
            bitCnt <= '0;
            if (state == ST_PRE) begin
              state <= ST_FRM;
            end else if (pagePending) begin
              pagePending <= 1'b0;
              state       <= preEn ? ST_PRE : ST_FRM;
            end else begin
              state    <= ST_IDLE;
              doneFlag <= 1'b1;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.loadWord = startReq || (lastBit && pagePending && !tmoHit);
    strb.shiftOut = fallTick && (state == ST_FRM) && (bitCnt != LAST_POS) && !tmoHit;
    strb.capture  = riseTick && (state == ST_FRM) && !pagePending && cmdRead && (bitCnt >= CAP_POS);
    strb.preamble = (state == ST_PRE);
    if (startReq) begin
      loadVal = pageEn ? buildPage(wrData[PHY_LSB +: PHY_W])
                       : buildMain({wrData[29:18], wrData[15:0]});
    end else begin
      loadVal = buildMain(cmdReg);
    end
  end

  always_comb begin
    mdioOe = 1'b0;
    if (state == ST_PRE) begin
      mdioOe = 1'b1;
    end else if (state == ST_FRM) begin
      mdioOe = !(cmdRead && !pagePending && (bitCnt >= REL_POS));
    end
  end

  always_comb begin
    ctlReadback = '0;
    ctlReadback[DIV_W-1:0]                = div;
    ctlReadback[CTL_PRE]                  = preEn;
    ctlReadback[CTL_DONE]                 = doneFlag;
    ctlReadback[CTL_BUSY]                 = busy;
    ctlReadback[CTL_ERR]                  = errFlag;
    ctlReadback[CTL_PAGE]                 = pageEn;
    ctlReadback[CTL_TMO_LSB +: TMO_W]     = tmoLimit;
  end

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && busy));

  assert_release_only_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !mdioOe) |-> (cmdRead && !pagePending));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && datWr) |=> $stable(cmdReg));

  assert_err_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && busy));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h128,
  parameter logic [ADDR_W-1:0] DATA_OFS = 12'h12C,
  parameter int              DIV_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  logic                  ctlWr;
  logic                  datWr;
  logic                  run;
  logic [DIV_W-1:0]      div;
  logic                  riseTick;
  logic                  fallTick;
  mdioStrb_t             strb;
  logic [FRAME_BITS-1:0] loadVal;
  logic [31:0]           ctlReadback;
  logic [15:0]           rdData;

  assign ctlWr = busWrEn && (busAddr == CTRL_OFS);
  assign datWr = busWrEn && (busAddr == DATA_OFS);

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .datWr(datWr), .wrData(busWrData),
    .riseTick(riseTick), .fallTick(fallTick), .run(run), .div(div),
    .strb(strb), .loadVal(loadVal), .mdioOe(mdioOe), .ctlReadback(ctlReadback)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .run(run), .div(div),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdData(rdData)
  );

  always_comb begin
    if (busAddr == CTRL_OFS) begin
      busRdData = ctlReadback;
    end else if (busAddr == DATA_OFS) begin
      busRdData = {16'h0000, rdData};
    end else begin
      busRdData = '0;
    end
  end

  // R3: while a transaction is running, data changes only with a falling MDC edge
  assert_out_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$stable(mdioOut)) |-> $fell(mdc));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] DATA = 12'h12C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    int          preLen;
    logic [31:0] word;
    int          relIdx;
    string       tag;
  } expFrame_t;

  expFrame_t expQ[$];
  expFrame_t cur;
  bit          inFrame = 0;
  bit          monOn = 1;
  bit          bad;
  int          pos, k;
  int          riseCnt = 0;
  int          strayCnt = 0;
  logic        mdcPrev = 1'b0;
  logic [31:0] actW, expW;
  logic        expOe;

  always @(negedge clk) begin
    if (mdc && !mdcPrev) begin
      riseCnt++;
      if (!inFrame && expQ.size() > 0) begin
        cur = expQ.pop_front();
        inFrame = 1; pos = 0; actW = '0; expW = '0; bad = 0;
      end
      if (inFrame) begin
        if (pos < cur.preLen) begin
          if (!(mdioOe && mdioOut)) bad = 1;
        end else begin
          k = pos - cur.preLen;
          expOe = (k < cur.relIdx);
          if (mdioOe !== expOe) bad = 1;
          if (mdioOe) actW[31-k] = mdioOut;
          if (expOe) expW[31-k] = cur.word[31-k];
        end
        if (pos == cur.preLen + 31) begin
          inFrame = 0;
          check(!bad && (actW == expW), cur.tag, actW, expW);
        end
        pos++;
      end else if (monOn) begin
        strayCnt++;
      end
    end
    mdcPrev = mdc;
  end

  // PHY reply model: drives on falling edges while the master has released the line
  logic [15:0] resp = 16'h0;
  logic        phyPrev = 1'b0;
  int          fallK = 0;

  always @(negedge clk) begin
    if (phyPrev && !mdc && !mdioOe) begin
      if (fallK == 0) mdioIn = 1'b0;
      else if (fallK <= 16) mdioIn = resp[16-fallK];
      else mdioIn = 1'b1;
      fallK++;
    end
    if (mdioOe) begin
      fallK = 0;
      mdioIn = 1'b1;
    end
    phyPrev = mdc;
  end

  task automatic writeReg(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      readReg(CTRL, v);
      n++;
    end while (v[9] && n < 5000);
  endtask

  function automatic logic [31:0] frameWord(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cmdA, cmdB, cmdC;
    int r0, per, t, t0, edges;
    logic p;

    cmdA = 32'h5002_0000 | (32'd3 << 23) | (32'd9 << 18) | 32'h1234;
    cmdB = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18);
    cmdC = 32'h5000_0000 | (32'd5 << 23) | (32'd4 << 18) | 32'hBEEF;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readReg(CTRL, v); check(v == 0, "R1 ctrl reset", v, 0);
    readReg(DATA, v); check(v == 0, "R1 data reset", v, 0);
    check(mdc == 0 && mdioOe == 0, "R1 pins idle", {30'd0, mdc, mdioOe}, 0);

    // R3 write frame, divisor 1, no preamble
    writeReg(CTRL, 32'h1);
    expQ.push_back('{0, frameWord(2'b01, 5'd3, 5'd9, 16'h1234), 32, "R3 write frame"});
    writeReg(DATA, cmdA);
    waitIdle();
    readReg(CTRL, v); check(v == 32'h101, "R4 done after write", v, 32'h101);
    writeReg(CTRL, 32'h0);
    readReg(CTRL, v); check(v == 0, "R8 ctrl zero clears done", v, 0);

    // R5/R11 read frame with preamble, divisor 2
    writeReg(CTRL, 32'h82);
    resp = 16'hA5C3;
    expQ.push_back('{32, frameWord(2'b10, 5'd1, 5'd2, 16'h0), 15, "R5 R11 read frame"});
    writeReg(DATA, cmdB);
    t = 0; t0 = 0; edges = 0; per = 0; p = mdc;
    while (edges < 2) begin
      @(negedge clk); t++;
      if (mdc && !p) begin
        edges++;
        if (edges == 1) t0 = t; else per = t - t0;
      end
      p = mdc;
    end
    check(per == 6, "R12 mdc period", per, 6);
    readReg(CTRL, v); check(v[9] == 1'b1, "R7 busy visible", v, 32'h282);
    writeReg(DATA, cmdA);   // must be ignored
    waitIdle();
    readReg(DATA, v); check(v == 32'h0000A5C3, "R6 read data", v, 32'h0000A5C3);
    readReg(CTRL, v); check(v == 32'h182, "R4 done after read", v, 32'h182);

    // R9 page select with preamble, divisor 0
    writeReg(CTRL, 32'h880);
    expQ.push_back('{32, frameWord(2'b01, 5'd0, 5'h1F, 16'h0050), 32, "R9 page frame"});
    expQ.push_back('{32, frameWord(2'b01, 5'd5, 5'd4, 16'hBEEF), 32, "R9 command frame"});
    writeReg(DATA, cmdC);
    waitIdle();
    readReg(CTRL, v); check(v == 32'h980, "R9 done after both", v, 32'h980);

    // R2 malformed commands
    writeReg(CTRL, 32'h0);
    r0 = riseCnt;
    writeReg(DATA, 32'h7000_1234);
    writeReg(DATA, 32'h2000_0000);
    writeReg(DATA, 32'h1000_0000);
    repeat (30) @(negedge clk);
    check(riseCnt == r0, "R2 no clock for bad command", riseCnt, r0);
    readReg(CTRL, v); check(v == 0, "R2 stays idle", v, 0);

    // R10 timeout
    monOn = 0;
    writeReg(CTRL, 32'h000A_0000);
    r0 = riseCnt;
    writeReg(DATA, cmdA);
    waitIdle();
    readReg(CTRL, v); check(v == 32'h000A_0400, "R10 error flag", v, 32'h000A_0400);
    check(riseCnt - r0 == 10, "R10 edge count", riseCnt - r0, 10);
    repeat (10) @(negedge clk);
    check(mdc == 0 && riseCnt - r0 == 10, "R10 clock stopped", riseCnt - r0, 10);
    writeReg(CTRL, 32'h0);
    readReg(CTRL, v); check(v == 0, "R8 clear error", v, 0);
    monOn = 1;

    check(strayCnt == 0, "R7 no extra frame", strayCnt, 0);
    check(expQ.size() == 0 && !inFrame, "R3 all frames seen", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule